// File: doc/BRIEF.md
# Strobe-Latched Serial Register Receiver

This block sits on the target side of a three-wire write link made of a serial clock, a serial data line and an active-low strobe. It samples all three wires in its own clock domain, shifts a 32-bit data word and then an 8-bit address in on rising serial-clock edges, and accepts one trailing read/write flag bit while the strobe is low. When the strobe returns high, a complete frame whose flag is 1 updates one register of a small local register file.

Most registers drive board-level control bits and are shown on a flat output bus. One fixed address holds a reset-control register. Writing the value 1 to it raises a reset request to the host processor for a fixed number of local clocks. At the end of that pulse the register clears itself to 0.

Top module: `sreg_rx`

## Requirements
- R1: Bits are taken on rising edges of `sclk_i` while `stb_ni` is high. The first 32 bits form the data word, most significant bit first.
- R2: The 8 bits after the data word form the address, most significant bit first.
- R3: A write is committed only when `stb_ni` rises after exactly 40 bits taken with the strobe high, followed by exactly one bit taken with the strobe low whose value is 1. A flag of 0 commits nothing.
- R4: The frame is discarded and nothing changes in any of these cases: fewer than 40 bits, more than 40 bits with the strobe high, or a missing flag bit. The bit count restarts at every strobe rise, so the next frame is unaffected.
- R5: General registers sit at addresses 0 to NUM_REGS-1. Register k appears on `regs_o[32k+31:32k]`. A register changes only on a committed write to its own address.
- R6: A committed write to any other address leaves `regs_o` and `rst_ctrl_o` unchanged and raises no reset.
- R7: A committed write of the value 1 to address RST_ADDR (default 0x80) drives `rst_req_o` high for exactly RST_CYC consecutive clocks.
- R8: `rst_ctrl_o` reads 0 after the pulse ends. A write of any other value to RST_ADDR is stored in `rst_ctrl_o` and raises no pulse.
- R9: While the reset pulse is active, `rst_ctrl_o` holds 1. Writes to RST_ADDR are ignored and do not lengthen the pulse.
- R10: After reset, `regs_o` and `rst_ctrl_o` are 0 and `rst_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk_i` |
| sdata_i | input | 1 | Serial data, asynchronous |
| stb_ni | input | 1 | Active-low strobe, asynchronous |
| regs_o | output | NUM_REGS*32 | Flat view of the general registers |
| rst_ctrl_o | output | 32 | Reset-control register value |
| rst_req_o | output | 1 | Reset request pulse to the host processor |

## Verification
The bench builds the block with NUM_REGS of 4 and RST_CYC of 300. The short pulse keeps many random reset writes affordable. It is also longer than one full 41-bit frame at the bench's serial rate, so a second write to the reset-control address can land while a pulse is still active. Four registers leave room for address bit-order errors to show: a reversed address of 0x01 would alias to 0x80, and addresses just past the map must be ignored.

// File: rtl/sreg_rx_pkg.sv
package sreg_rx_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int FRAME_HI = DATA_W + ADDR_W;
  localparam int CNT_W    = 6;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sreg_rx_sync.sv
module sreg_rx_sync #(
  parameter int         WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[g]}};
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/sreg_rx_frame.sv
module sreg_rx_frame
  import sreg_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             sdata_s_i,
  input  logic             stb_ns_i,
  output wr_req_t          wr_o,
  output logic             stb_rise_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_HI   = CNT_W'(FRAME_HI);
  localparam logic [CNT_W-1:0] CNT_FLAG = CNT_W'(FRAME_HI + 1);
  localparam logic [CNT_W-1:0] CNT_BAD  = '1;

  logic                sclk_d_q, stb_d_q;
  logic                sclk_rise, stb_rise;
  logic [CNT_W-1:0]    cnt_q;
  logic [FRAME_HI-1:0] sh_q;
  logic                flag_q;

  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign stb_rise  = stb_ns_i & ~stb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      stb_d_q  <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s_i;
      stb_d_q  <= stb_ns_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      flag_q <= 1'b0;
      wr_o   <= '0;
    end else begin
      wr_o.valid <= 1'b0;
      if (stb_rise) begin
        // strobe rise ends every frame, valid or not
        if (cnt_q == CNT_FLAG && flag_q) begin
          wr_o.valid <= 1'b1;
          wr_o.data  <= sh_q[FRAME_HI-1:ADDR_W];
          wr_o.addr  <= sh_q[ADDR_W-1:0];
        end
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else if (sclk_rise) begin
        if (stb_ns_i) begin
          if (cnt_q < CNT_HI) begin
            sh_q  <= {sh_q[FRAME_HI-2:0], sdata_s_i};
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= CNT_BAD;
          end
        end else if (cnt_q == CNT_HI) begin
          flag_q <= sdata_s_i;
          cnt_q  <= CNT_FLAG;
        end else begin
          cnt_q <= CNT_BAD;
        end
      end
    end
  end

  assign stb_rise_o = stb_rise;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/sreg_rx_regs.sv
module sreg_rx_regs
  import sreg_rx_pkg::*;
#(
  parameter int                NUM_REGS = 4,
  parameter int                RST_CYC  = 2048,
  parameter logic [ADDR_W-1:0] RST_ADDR = 8'h80
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  wr_req_t                    wr_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [DATA_W-1:0]          rst_ctrl_o,
  output logic                       rst_req_o
);
  localparam int PW = $clog2(RST_CYC + 1);
  localparam logic [PW-1:0] P_LAST = PW'(RST_CYC - 1);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic              hit;
    assign hit = wr_i.valid && (wr_i.addr == ADDR_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (hit) r_q <= wr_i.data;
    end
    assign regs_o[k*DATA_W +: DATA_W] = r_q;
  end

  logic [DATA_W-1:0] ctrl_q;
  logic              act_q;
  logic [PW-1:0]     pcnt_q;
  logic              ctrl_hit;

  assign ctrl_hit = wr_i.valid && (wr_i.addr == RST_ADDR) && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (act_q) begin
      if (pcnt_q == '0) begin
        act_q  <= 1'b0;
        ctrl_q <= '0;
      end else begin
        pcnt_q <= pcnt_q - 1'b1;
      end
    end else if (ctrl_hit) begin
      ctrl_q <= wr_i.data;
      if (wr_i.data == DATA_W'(1)) begin
        act_q  <= 1'b1;
        pcnt_q <= P_LAST;
      end
    end
  end

  assign rst_ctrl_o = ctrl_q;
  assign rst_req_o  = act_q;
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
  import sreg_rx_pkg::*;
#(
  parameter int                NUM_REGS = 4,
  parameter int                RST_CYC  = 2048,
  parameter logic [ADDR_W-1:0] RST_ADDR = 8'h80
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  input  logic                       stb_ni,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [DATA_W-1:0]          rst_ctrl_o,
  output logic                       rst_req_o
);
  logic [2:0]       sync_q;
  wr_req_t          wr;
  logic             stb_rise;
  logic [CNT_W-1:0] frm_cnt;

  sreg_rx_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({stb_ni, sdata_i, sclk_i}),
    .q_o    (sync_q)
  );

  sreg_rx_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sync_q[0]),
    .sdata_s_i  (sync_q[1]),
    .stb_ns_i   (sync_q[2]),
    .wr_o       (wr),
    .stb_rise_o (stb_rise),
    .cnt_o      (frm_cnt)
  );

  sreg_rx_regs #(.NUM_REGS(NUM_REGS), .RST_CYC(RST_CYC), .RST_ADDR(RST_ADDR)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .regs_o     (regs_o),
    .rst_ctrl_o (rst_ctrl_o),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: rtl/sreg_rx_chk.sv
module sreg_rx_chk
  import sreg_rx_pkg::*;
#(
  parameter int                NUM_REGS = 4,
  parameter int                RST_CYC  = 2048,
  parameter logic [ADDR_W-1:0] RST_ADDR = 8'h80
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input wr_req_t                    wr,
  input logic                       stb_rise,
  input logic [CNT_W-1:0]           frm_cnt,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic [DATA_W-1:0]          rst_ctrl_o,
  input logic                       rst_req_o
);
  localparam int HW = $clog2(RST_CYC + 2);
  logic [HW-1:0] hi_cnt;
  logic          in_map;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (rst_req_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  assign in_map = (wr.addr < ADDR_W'(NUM_REGS)) || (wr.addr == RST_ADDR);

  p_commit_on_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr.valid |-> $past(stb_rise));

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_cnt <= CNT_W'(FRAME_HI + 1)) || (frm_cnt == '1));

  p_regs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr.valid) |-> $stable(regs_o));

  p_bad_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr.valid && !in_map) |-> ($stable(regs_o) && !$rose(rst_req_o)));

  p_pulse_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(wr.valid && wr.addr == RST_ADDR && wr.data == DATA_W'(1)));

  p_pulse_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (hi_cnt < HW'(RST_CYC)));

  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (hi_cnt == HW'(RST_CYC)));

  p_ctrl_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (rst_ctrl_o == '0));

  p_ctrl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_ctrl_o == DATA_W'(1)));
endmodule

bind sreg_rx sreg_rx_chk #(.NUM_REGS(NUM_REGS), .RST_CYC(RST_CYC), .RST_ADDR(RST_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr         (wr),
  .stb_rise   (stb_rise),
  .frm_cnt    (frm_cnt),
  .regs_o     (regs_o),
  .rst_ctrl_o (rst_ctrl_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/sreg_rx_tb.sv
module sreg_rx_tb;
  localparam int NR  = 4;
  localparam int RC  = 300;
  localparam logic [7:0] RA = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, stb_n = 1'b1;
  logic [NR*32-1:0] regs;
  logic [31:0] ctrl;
  logic rst_req;

  int checks = 0, errors = 0, hi_total = 0;
  bit done = 0;
  logic [31:0] exp_r [NR];
  logic [31:0] exp_ctrl = '0;

  always #5 clk = ~clk;

  sreg_rx #(.NUM_REGS(NR), .RST_CYC(RC), .RST_ADDR(RA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .stb_ni(stb_n),
    .regs_o(regs), .rst_ctrl_o(ctrl), .rst_req_o(rst_req)
  );

  always @(negedge clk) if (rst_req) hi_total++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b);
    sdata = b; wait_clk(3);
    sclk = 1'b1; wait_clk(3);
    sclk = 1'b0;
  endtask

  // nhi bits with strobe high, optional flag bit with strobe low
  task automatic frame(input logic [31:0] d, input logic [7:0] a, input int nhi,
                       input bit fclk, input logic flag);
    logic [39:0] bits;
    bits = {d, a};
    for (int i = 0; i < nhi; i++) bit_clk(i < 40 ? bits[39-i] : 1'b0);
    stb_n = 1'b0; wait_clk(3);
    if (fclk) bit_clk(flag);
    wait_clk(3);
    stb_n = 1'b1;
    wait_clk(2);
  endtask

  function automatic bit commits(input int nhi, input bit fclk, input logic flag);
    return (nhi == 40) && fclk && flag;
  endfunction

  // model: returns expected pulse cycles
  function automatic int apply(input logic [31:0] d, input logic [7:0] a);
    if (a < NR) exp_r[a] = d;
    else if (a == RA) begin
      if (d == 32'd1) begin exp_ctrl = '0; return RC; end
      exp_ctrl = d;
    end
    return 0;
  endfunction

  task automatic check_all(input string tag);
    for (int k = 0; k < NR; k++)
      chk(regs[k*32 +: 32] === exp_r[k], tag, regs[k*32 +: 32], exp_r[k]);
    chk(ctrl === exp_ctrl, tag, ctrl, exp_ctrl);
  endtask

  task automatic run(input logic [31:0] d, input logic [7:0] a, input int nhi,
                     input bit fclk, input logic flag, input string tag);
    int h0, ep;
    h0 = hi_total;
    frame(d, a, nhi, fclk, flag);
    ep = commits(nhi, fclk, flag) ? apply(d, a) : 0;
    wait_clk(RC + 20);
    chk(hi_total - h0 == ep, {tag, " pulse R7"}, hi_total - h0, ep);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h0;
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < NR; k++) exp_r[k] = '0;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    // R10 reset state
    check_all("R10 reset");
    chk(rst_req === 1'b0, "R10 rst_req", rst_req, 0);

    // R1 R2 bit order: reversed address 0x01 would hit 0x80
    run(32'h8000_0001, 8'h01, 40, 1, 1, "R1 R2 msb-first");
    run(32'h1234_5678, 8'h02, 40, 1, 1, "R1 data");
    // R3 flag 0 commits nothing
    run(32'hdead_beef, 8'h00, 40, 1, 0, "R3 flag0");
    // R4 short, long, missing flag
    run(32'hffff_ffff, 8'h03, 39, 1, 1, "R4 short");
    run(32'haaaa_5555, 8'h03, 41, 1, 1, "R4 long");
    run(32'h0f0f_0f0f, 8'h03, 40, 0, 1, "R4 noflag");
    run(32'h0000_0077, 8'h03, 40, 1, 1, "R4 after-discard");
    // R6 unimplemented addresses
    run(32'hcafe_f00d, 8'h04, 40, 1, 1, "R6 addr4");
    run(32'h0000_0001, 8'h81, 40, 1, 1, "R6 addr81");
    // R8 non-one value stored, no pulse
    run(32'h0000_0002, RA, 40, 1, 1, "R8 store");
    // R7 R8 reset write
    run(32'h0000_0001, RA, 40, 1, 1, "R7 R8 reset");

    // R9: second write during active pulse is ignored
    h0 = hi_total;
    frame(32'h1, RA, 40, 1, 1);
    wait_clk(10);
    chk(ctrl === 32'd1, "R9 ctrl during pulse", ctrl, 1);
    frame(32'h0000_0005, RA, 40, 1, 1);
    wait_clk(5);
    chk(rst_req === 1'b1, "R9 still active", rst_req, 1);
    chk(ctrl === 32'd1, "R9 write ignored", ctrl, 1);
    wait_clk(RC + 20);
    exp_ctrl = '0;
    chk(hi_total - h0 == RC, "R9 pulse len", hi_total - h0, RC);
    check_all("R9 after");

    // R5 and mixed random frames
    for (int n = 0; n < 60; n++) begin
      logic [31:0] d;
      logic [7:0]  a;
      int sel, nhi;
      bit fclk;
      logic flag;
      sel = $urandom_range(0, 9);
      a = (sel < 5) ? 8'($urandom_range(0, NR-1)) : (sel < 7) ? RA : 8'($urandom);
      d = ($urandom_range(0, 3) == 0) ? 32'd1 : $urandom;
      sel = $urandom_range(0, 9);
      nhi = (sel == 0) ? $urandom_range(1, 39) : (sel == 1) ? 40 + $urandom_range(1, 3) : 40;
      fclk = (sel != 2);
      flag = (sel != 3);
      run(d, a, nhi, fclk, flag, "R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule